// File: doc/BRIEF.md
# Link Fault Monitor

This block decides whether a fiber link may carry traffic. It merges two local receive-channel alarms (loss of incoming signal and loss of clock-recovery lock) with a flag that says the link partner has reported a fault back to us. While any fault is present, the block leaves the good-link state. It then tells the transmitter to send only idle, cuts the media-independent data path off from the MAC, and sets a management-visible fault bit.

A local alarm must persist before it counts. A qualification timer, sized from the clock frequency, filters out short dropouts. The remote fault flag acts on the next clock edge with no delay. The block returns to the good-link state only when the remote flag is clear and the local channel is clean. All outputs are decoded from a registered three-state machine: good, qualifying and faulted.

Top module: `link_fault_monitor`

## Requirements
- R1: After reset, link_ok is 1 and mii_isolate, force_idle and link_fault are 0.
- R2: If remote_fault is 1 at a rising clock edge, the block is faulted after that edge. This holds whether it was in the good state or still qualifying a local error.
- R3: When faulted, link_ok is 0 and mii_isolate, force_idle and link_fault are 1. Otherwise these levels are inverted.
- R4: The local error is the OR of sig_err and lock_err. Either input alone, or both together, starts qualification.
- R5: The qualification length is QUAL = (CLK_HZ/1000)*QUAL_US/1000 cycles, which is 8250 at the defaults of 25 MHz and 330 µs. A local error sampled high on QUAL consecutive edges faults the block after the QUAL-th edge. It stays in the good state after QUAL-1 such edges.
- R6: If the local error is sampled low before qualification completes, the link stays good and the timer restarts. A later error again needs QUAL consecutive edges.
- R7: A faulted block stays faulted while remote_fault or the local error is 1. It returns to the good state after the first edge at which both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sig_err | input | 1 | Local loss of receive signal |
| lock_err | input | 1 | Local loss of clock-recovery lock |
| remote_fault | input | 1 | Link partner reported a fault |
| link_ok | output | 1 | 1 while the link is usable |
| mii_isolate | output | 1 | 1 to detach the data path from the MAC |
| force_idle | output | 1 | 1 to make the transmitter send only idle |
| link_fault | output | 1 | Management status bit, 1 while faulted |

## Verification
The bench builds the block with CLK_HZ = 1 MHz and QUAL_US = 6, which gives a six-cycle qualification window. At that size, error bursts from one to ten cycles long can be swept for each error source. This covers every length below, at and above the threshold, along with restart-after-gap patterns and every order in which the remote and local faults can clear.

// File: rtl/link_fault_monitor.sv
module link_fault_monitor #(
  parameter int CLK_HZ  = 25_000_000,
  parameter int QUAL_US = 330
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sig_err,
  input  logic lock_err,
  input  logic remote_fault,
  output logic link_ok,
  output logic mii_isolate,
  output logic force_idle,
  output logic link_fault
);

  localparam int QUAL = (CLK_HZ / 1000) * QUAL_US / 1000;
  localparam int CW   = $clog2(QUAL + 1);
  localparam logic [CW-1:0] QUAL_LAST = CW'(QUAL - 1);

  typedef enum logic [1:0] {ST_OK, ST_QUAL, ST_FAULT} st_t;

  st_t           state;
  logic [CW-1:0] qual_cnt;
  logic          local_err;

  assign local_err = sig_err | lock_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_OK;
      qual_cnt <= '0;
    end else begin
      case (state)
        ST_OK: begin
          if (remote_fault) state <= ST_FAULT;
          else if (local_err) begin
            state    <= ST_QUAL;
            qual_cnt <= CW'(1);
          end
        end
        ST_QUAL: begin
          if (remote_fault) begin
            state    <= ST_FAULT;
            qual_cnt <= '0;
          end else if (!local_err) begin
            state    <= ST_OK;
            qual_cnt <= '0;
          end else if (qual_cnt == QUAL_LAST) begin
            state    <= ST_FAULT;
            qual_cnt <= '0;
          end else begin
            qual_cnt <= qual_cnt + CW'(1);
          end
        end
        ST_FAULT: begin
          if (!remote_fault && !local_err) state <= ST_OK;
        end
        default: state <= ST_OK;
      endcase
    end
  end

  assign link_ok     = (state != ST_FAULT);
  assign mii_isolate = (state == ST_FAULT);
  assign force_idle  = (state == ST_FAULT);
  assign link_fault  = (state == ST_FAULT);

  initial assert (QUAL >= 2) else $error("qualification window too short");

  p_remote_fast_r2: assert property (@(posedge clk) disable iff (!rst_n)
    remote_fault |=> !link_ok);

  p_fault_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FAULT && $past(state) != ST_FAULT && !$past(remote_fault))
      |-> $past(local_err));

  p_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_QUAL && !local_err && !remote_fault) |=> (link_ok && qual_cnt == '0));

  p_recover_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FAULT && !remote_fault && !local_err) |=> link_ok);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_FAULT && (remote_fault || local_err)) |=> !link_ok);

  p_no_overflow_r5: assert property (@(posedge clk) disable iff (!rst_n)
    qual_cnt <= QUAL_LAST);

endmodule

// File: tb/link_fault_monitor_tb_top.sv
module link_fault_monitor_tb_top;
  localparam int CLK_HZ = 1_000_000;
  localparam int QUAL_US = 6;
  localparam int QUAL = (CLK_HZ / 1000) * QUAL_US / 1000;

  logic clk = 0, rst_n = 0;
  logic sig_err = 0, lock_err = 0, remote_fault = 0;
  logic link_ok, mii_isolate, force_idle, link_fault;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  link_fault_monitor #(.CLK_HZ(CLK_HZ), .QUAL_US(QUAL_US)) dut_i (
    .clk(clk), .rst_n(rst_n), .sig_err(sig_err), .lock_err(lock_err),
    .remote_fault(remote_fault), .link_ok(link_ok), .mii_isolate(mii_isolate),
    .force_idle(force_idle), .link_fault(link_fault));

  task automatic chk(string req, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s at %0t: got %b expected %b", req, $time, got, exp);
    end
  endtask

  // R3: all four outputs follow the fault state
  task automatic chk_state(string req, logic exp_ok);
    chk(req, link_ok, exp_ok);
    chk({req, "/R3"}, mii_isolate, !exp_ok);
    chk({req, "/R3"}, force_idle, !exp_ok);
    chk({req, "/R3"}, link_fault, !exp_ok);
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic set_err(int src, logic v);
    sig_err  = (src == 0 || src == 2) ? v : 1'b0;
    lock_err = (src == 1 || src == 2) ? v : 1'b0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cyc(); cyc();
    chk_state("R1", 1'b1);
    rst_n = 1;
    cyc();
    chk_state("R1", 1'b1);

    // R4/R5: burst length sweep for each error source
    for (int src = 0; src < 3; src++) begin
      for (int len = 1; len <= 10; len++) begin
        set_err(src, 1'b1);
        for (int k = 1; k <= len; k++) begin
          cyc();
          chk_state("R5", !(k >= QUAL));
        end
        set_err(src, 1'b0);
        cyc();
        chk_state("R4/R7", 1'b1);
      end
    end

    // R6: gap restarts the timer
    set_err(0, 1'b1);
    for (int k = 0; k < QUAL - 1; k++) cyc();
    set_err(0, 1'b0); cyc();
    chk_state("R6", 1'b1);
    set_err(1, 1'b1);
    for (int k = 0; k < QUAL - 1; k++) begin cyc(); chk_state("R6", 1'b1); end
    cyc();
    chk_state("R6", 1'b0);
    set_err(1, 1'b0); cyc();
    chk_state("R7", 1'b1);

    // R2: remote fault from good and during qualification
    remote_fault = 1; cyc();
    chk_state("R2", 1'b0);
    remote_fault = 0; cyc();
    chk_state("R7", 1'b1);
    set_err(0, 1'b1); cyc(); cyc(); cyc();
    chk_state("R2", 1'b1);
    remote_fault = 1; cyc();
    chk_state("R2", 1'b0);

    // R7: remote clears first, local still present
    remote_fault = 0;
    for (int k = 0; k < 3; k++) begin cyc(); chk_state("R7", 1'b0); end
    set_err(0, 1'b0); cyc();
    chk_state("R7", 1'b1);

    // R7: local fault, then remote added, local clears first
    set_err(2, 1'b1);
    for (int k = 0; k < QUAL; k++) cyc();
    chk_state("R5", 1'b0);
    remote_fault = 1; cyc();
    set_err(2, 1'b0);
    for (int k = 0; k < 3; k++) begin cyc(); chk_state("R7", 1'b0); end
    remote_fault = 0; cyc();
    chk_state("R7", 1'b1);

    // R1: reset in the middle of a fault
    remote_fault = 1; cyc();
    chk_state("R2", 1'b0);
    rst_n = 0; #1;
    chk_state("R1", 1'b1);
    remote_fault = 0; cyc();
    rst_n = 1; cyc();
    chk_state("R1", 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule